// File: doc/BRIEF.md
# Pre-length bitmap instruction splitter

This block sits between a halfword-aligned fetch buffer and the instruction decoder. It cuts the raw halfword stream into instructions. Instruction length is not taken from each instruction's own opcode bits. Instead, a 32-bit mode-switching word loads a short queue of length bits, and each queued bit fixes the size of one of the static instructions that follow. The mode-switching word is recognised by its primary opcode field. The compressed instruction carried inside it is issued as real work. Once the queue empties, the splitter falls back to plain 32-bit decoding.

Each cycle the fetch buffer presents a 32-bit window and the number of valid halfwords in it. The splitter answers in the same cycle with the instruction, a 16-bit/32-bit flag, a valid strobe, and how many halfwords to pop. A redirect (a taken branch or an exception entry) empties the queue, because branch targets are always uncompressed. The remaining queue contents and their count are visible on ports and can be written back. This lets an interrupt handler save and restore the pending compressed-mode state.

Top module: `prelen_splitter`

## Requirements
- R1: After reset the length queue is empty (ctx_cnt = 0, ctx_bits = 0) and the splitter decodes in plain 32-bit mode.
- R2: With the queue empty, a window with two valid halfwords whose bits [31:26] differ from SWITCH_OPC is issued whole as a 32-bit instruction: insn = win_data, insn_is16 = 0, consume = 2. The first halfword in program order is win_data[31:16].
- R3: A 32-bit slot whose bits [31:26] equal SWITCH_OPC (default 6'h05) is a mode-switching word. Its embedded compressed instruction, bits [25:10], is issued zero-extended with insn_is16 = 1 and consume = 2.
- R4: A mode-switching word loads its bits [9:0] as length bits and sets the count to 10. Bit 0 covers the next instruction, bit 1 the one after, and so on. A bit of 1 makes that instruction 16 bits and a bit of 0 makes it 32 bits. Each issued instruction uses up one bit.
- R5: In a 16-bit slot the splitter issues win_data[31:16] zero-extended with insn_is16 = 1 and consume = 1. A 16-bit slot is never taken for a mode-switching word, whatever its top bits hold.
- R6: After all 10 length bits are used, the count is 0 and the next instruction is decoded in 32-bit mode.
- R7: A mode-switching word met in a 32-bit slot while bits are still queued discards them. It loads its own 10 bits with the count set to 10.
- R8: A redirect drops insn_valid and consume to 0 in its cycle and empties the queue. The next instruction is decoded in 32-bit mode. A redirect wins over a simultaneous restore.
- R9: When win_hw is smaller than the current slot needs (1 for a 16-bit slot, 2 for a 32-bit slot), insn_valid = 0, consume = 0 and the queue is unchanged.
- R10: ctx_bits shows the queued bits with the next one at bit 0, and ctx_cnt shows their count. A restore_en cycle (without redirect) issues nothing and loads restore_bits and restore_cnt. A count above 10 is clipped to 10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_data | input | 32 | Fetch window; first halfword in [31:16] |
| win_hw | input | 2 | Valid halfwords in the window (0..2) |
| redirect | input | 1 | Control-flow redirect; empties the queue |
| restore_en | input | 1 | Load queue state from the restore ports |
| restore_bits | input | 10 | Length bits to restore |
| restore_cnt | input | 4 | Count of valid restored bits |
| insn | output | 32 | Issued instruction (16-bit forms zero-extended) |
| insn_is16 | output | 1 | Issued instruction is a compressed one |
| insn_valid | output | 1 | An instruction is issued this cycle |
| consume | output | 2 | Halfwords to pop from the fetch buffer |
| ctx_bits | output | 10 | Queued length bits, next at bit 0 |
| ctx_cnt | output | 4 | Number of queued length bits |

## Verification
The bench sweeps all 1024 length bitmaps behind a mode-switching word and checks each of the ten following slots. If a design took the bits from the wrong end, or mixed up the 1 and 0 meaning, the wrong halfword count would be popped within the first mismatching slot. The 16-bit slots carry halfwords whose top six bits equal the switching opcode. A design that ran opcode detection there would issue an embedded field and pop two halfwords. The bench also checks that the queue drains to 32-bit mode on the eleventh slot. It checks that a second switching word overwrites the remaining bits rather than merging with them. Stalls with too few halfwords must leave the queue untouched. A redirect must beat a restore, and an oversized restore count must be clipped. Each of these fails at the port if it is handled wrongly.

// File: rtl/prelen_pkg.sv
package prelen_pkg;

   localparam int HALF_W = 16;
   localparam int WORD_W = 32;

   typedef enum logic [1:0] {
      SLOT_WORD   = 2'd0,
      SLOT_HALF   = 2'd1,
      SLOT_SWITCH = 2'd2
   } slot_e;

endpackage

// File: rtl/prelen_lenq.sv
module prelen_lenq #(
   parameter int NBITS = 10,
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             restore,
   input  logic [NBITS-1:0] rbits,
   input  logic [CNT_W-1:0] rcnt,
   input  logic             load,
   input  logic [NBITS-1:0] lbits,
   input  logic             advance,
   output logic [NBITS-1:0] bits,
   output logic [CNT_W-1:0] cnt
);

   localparam logic [CNT_W-1:0] FULL = CNT_W'(NBITS);

   logic [CNT_W-1:0] cnt_q, cnt_d, rcnt_clip;
   logic [NBITS-1:0] bits_q, bits_d;

   assign rcnt_clip = (rcnt > FULL) ? FULL : rcnt;

   always_comb begin
      if (clear)                          cnt_d = '0;
      else if (restore)                   cnt_d = rcnt_clip;
      else if (load)                      cnt_d = FULL;
      else if (advance && cnt_q != '0)    cnt_d = cnt_q - CNT_W'(1);
      else                                cnt_d = cnt_q;
   end

   for (genvar i = 0; i < NBITS; i++) begin : g_bit
      logic upper;
      if (i == NBITS - 1) begin : g_top
         assign upper = 1'b0;
      end else begin : g_mid
         assign upper = bits_q[i+1];
      end
      always_comb begin
         if (clear)        bits_d[i] = 1'b0;
         else if (restore) bits_d[i] = rbits[i];
         else if (load)    bits_d[i] = lbits[i];
         else if (advance) bits_d[i] = upper;
         else              bits_d[i] = bits_q[i];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         bits_q <= '0;
      end else begin
         cnt_q  <= cnt_d;
         bits_q <= bits_d;
      end
   end

   assign bits = bits_q;
   assign cnt  = cnt_q;

endmodule

// File: rtl/prelen_classify.sv
module prelen_classify #(
   parameter int          OPC_W      = 6,
   parameter int unsigned SWITCH_OPC = 5
) (
   input  logic [OPC_W-1:0]     opc,
   input  logic [1:0]           hw,
   input  logic                 pend,
   input  logic                 head16,
   output prelen_pkg::slot_e    slot,
   output logic                 ready
);
   import prelen_pkg::*;

   logic opc_hit;
   assign opc_hit = (opc == OPC_W'(SWITCH_OPC));

   always_comb begin
      if (pend && head16) begin
         slot  = SLOT_HALF;
         ready = (hw >= 2'd1);
      end else begin
         slot  = opc_hit ? SLOT_SWITCH : SLOT_WORD;
         ready = (hw >= 2'd2);
      end
   end

endmodule

// File: rtl/prelen_splitter.sv
module prelen_splitter #(
   parameter int          OPC_W      = 6,
   parameter int unsigned SWITCH_OPC = 5,
   localparam int         NBITS      = 32 - 16 - OPC_W,
   localparam int         CNT_W      = $clog2(NBITS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [31:0]      win_data,
   input  logic [1:0]       win_hw,
   input  logic             redirect,
   input  logic             restore_en,
   input  logic [NBITS-1:0] restore_bits,
   input  logic [CNT_W-1:0] restore_cnt,
   output logic [31:0]      insn,
   output logic             insn_is16,
   output logic             insn_valid,
   output logic [1:0]       consume,
   output logic [NBITS-1:0] ctx_bits,
   output logic [CNT_W-1:0] ctx_cnt
);
   import prelen_pkg::*;

   localparam int EMB_HI = WORD_W - 1 - OPC_W;

   if (OPC_W < 1 || OPC_W > 15) begin : g_bad_opc_w
      $error("prelen_splitter: OPC_W must be 1..15");
   end
   if (SWITCH_OPC >= (1 << OPC_W)) begin : g_bad_opc
      $error("prelen_splitter: SWITCH_OPC does not fit OPC_W");
   end

   slot_e slot;
   logic  ready, fire, busy;
   logic [NBITS-1:0] q_bits;
   logic [CNT_W-1:0] q_cnt;

   prelen_classify #(
      .OPC_W      (OPC_W),
      .SWITCH_OPC (SWITCH_OPC)
   ) u_classify (
      .opc    (win_data[WORD_W-1 -: OPC_W]),
      .hw     (win_hw),
      .pend   (q_cnt != '0),
      .head16 (q_bits[0]),
      .slot   (slot),
      .ready  (ready)
   );

   assign busy = redirect | restore_en;
   assign fire = ready & ~busy;

   prelen_lenq #(
      .NBITS (NBITS),
      .CNT_W (CNT_W)
   ) u_lenq (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (redirect),
      .restore (restore_en),
      .rbits   (restore_bits),
      .rcnt    (restore_cnt),
      .load    (fire && slot == SLOT_SWITCH),
      .lbits   (win_data[NBITS-1:0]),
      .advance (fire && slot != SLOT_SWITCH),
      .bits    (q_bits),
      .cnt     (q_cnt)
   );

   always_comb begin
      unique case (slot)
         SLOT_HALF:   insn = {{HALF_W{1'b0}}, win_data[WORD_W-1 -: HALF_W]};
         SLOT_SWITCH: insn = {{HALF_W{1'b0}}, win_data[EMB_HI -: HALF_W]};
         default:     insn = win_data;
      endcase
   end

   assign insn_is16  = (slot != SLOT_WORD);
   assign insn_valid = fire;
   assign consume    = !fire ? 2'd0 : (slot == SLOT_HALF) ? 2'd1 : 2'd2;
   assign ctx_bits   = q_bits;
   assign ctx_cnt    = q_cnt;

endmodule

// File: rtl/prelen_splitter_chk.sv
module prelen_splitter_chk #(
   parameter int NBITS = 10,
   parameter int CNT_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic [31:0]      win_data,
   input logic             redirect,
   input logic             restore_en,
   input logic [CNT_W-1:0] restore_cnt,
   input logic             insn_is16,
   input logic             insn_valid,
   input logic [1:0]       consume,
   input logic [NBITS-1:0] ctx_bits,
   input logic [CNT_W-1:0] ctx_cnt
);

   // R9
   idle_no_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !insn_valid |-> consume == 2'd0);

   // R6
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctx_cnt <= CNT_W'(NBITS));

   // R5
   half_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (insn_valid && ctx_cnt != '0 && ctx_bits[0]) |-> (consume == 2'd1 && insn_is16));

   // R3
   switch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (insn_valid && insn_is16 && consume == 2'd2) |=>
         (ctx_cnt == CNT_W'(NBITS) && ctx_bits == $past(win_data[NBITS-1:0])));

   // R4
   use_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (insn_valid && !(insn_is16 && consume == 2'd2) && ctx_cnt != '0) |=>
         ctx_cnt == $past(ctx_cnt) - CNT_W'(1));

   // R2
   plain_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (insn_valid && !insn_is16 && ctx_cnt == '0) |=> ctx_cnt == '0);

   // R8
   redirect_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      redirect |=> ctx_cnt == '0);

   // R10
   restore_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (restore_en && !redirect && restore_cnt <= CNT_W'(NBITS)) |=>
         ctx_cnt == $past(restore_cnt));

endmodule

bind prelen_splitter prelen_splitter_chk #(
   .NBITS (NBITS),
   .CNT_W (CNT_W)
) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .win_data    (win_data),
   .redirect    (redirect),
   .restore_en  (restore_en),
   .restore_cnt (restore_cnt),
   .insn_is16   (insn_is16),
   .insn_valid  (insn_valid),
   .consume     (consume),
   .ctx_bits    (ctx_bits),
   .ctx_cnt     (ctx_cnt)
);

// File: tb/test_prelen_splitter.sv
`timescale 1ns/1ps
module test_prelen_splitter;

   localparam logic [5:0] SWOPC = 6'h05;
   localparam logic [5:0] PLAIN = 6'h2A;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] win_data = '0;
   logic [1:0]  win_hw = '0;
   logic        redirect = 1'b0;
   logic        restore_en = 1'b0;
   logic [9:0]  restore_bits = '0;
   logic [3:0]  restore_cnt = '0;
   logic [31:0] insn;
   logic        insn_is16, insn_valid;
   logic [1:0]  consume;
   logic [9:0]  ctx_bits;
   logic [3:0]  ctx_cnt;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   prelen_splitter #(.OPC_W(6), .SWITCH_OPC(5)) i_prelen_splitter (
      .clk(clk), .rst_n(rst_n), .win_data(win_data), .win_hw(win_hw),
      .redirect(redirect), .restore_en(restore_en),
      .restore_bits(restore_bits), .restore_cnt(restore_cnt),
      .insn(insn), .insn_is16(insn_is16), .insn_valid(insn_valid),
      .consume(consume), .ctx_bits(ctx_bits), .ctx_cnt(ctx_cnt));

   task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   function automatic logic [35:0] o16(input logic [15:0] h);
      return {1'b1, 1'b1, 2'd1, 16'h0, h};
   endfunction
   function automatic logic [35:0] o32(input logic [31:0] w);
      return {1'b1, 1'b0, 2'd2, w};
   endfunction
   function automatic logic [35:0] osw(input logic [15:0] e);
      return {1'b1, 1'b1, 2'd2, 16'h0, e};
   endfunction

   function automatic logic [35:0] outs();
      return {insn_valid, insn_is16, consume, insn};
   endfunction
   function automatic logic [35:0] idle();
      return {33'h0, insn_valid, consume};
   endfunction
   function automatic logic [35:0] ctx();
      return {22'h0, ctx_cnt, ctx_bits};
   endfunction
   function automatic logic [35:0] ectx(input int c, input logic [9:0] b);
      return {22'h0, 4'(c), b};
   endfunction

   task automatic apply(input logic [31:0] w, input logic [1:0] hw);
      win_data = w;
      win_hw   = hw;
      #4;
   endtask

   task automatic adv();
      @(posedge clk);
      #1;
   endtask

   function automatic logic [31:0] swword(input logic [15:0] e, input logic [9:0] m);
      return {SWOPC, e, m};
   endfunction

   initial begin
      #2_000_000;
      n_bad++;
      $display("FAIL watchdog act=running exp=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      apply(32'h0, 2'd0);
      chk("R1 ctx", ctx(), ectx(0, 10'h0));
      chk("R1 idle", idle(), 36'h0);
      // R2 plain word
      apply({PLAIN, 26'h123_4567}, 2'd2);
      chk("R2 plain", outs(), o32({PLAIN, 26'h123_4567}));
      adv();
      chk("R2 ctx", ctx(), ectx(0, 10'h0));

      // R3 R4 R5 R6 sweep of every bitmap
      for (int m = 0; m < 1024; m++) begin
         logic [15:0] e;
         e = 16'(m * 3 + 1);
         apply(swword(e, 10'(m)), 2'd2);
         chk("R3 embedded", outs(), osw(e));
         adv();
         chk("R4 load", ctx(), ectx(10, 10'(m)));
         for (int k = 0; k < 10; k++) begin
            if (m[k]) begin
               logic [15:0] h;
               h = {SWOPC, 10'(m + k)};
               apply({h, 16'hFFFF}, 2'd2);
               chk("R5 half slot", outs(), o16(h));
            end else begin
               logic [31:0] w;
               w = {PLAIN, 26'(m * 7 + k)};
               apply(w, 2'd2);
               chk("R4 word slot", outs(), o32(w));
            end
            adv();
         end
         chk("R6 drained", ctx(), ectx(0, 10'h0));
         apply({PLAIN, 26'(m)}, 2'd2);
         chk("R6 back to word", outs(), o32({PLAIN, 26'(m)}));
         adv();
      end

      // R9 stalls
      apply(swword(16'hBEEF, 10'b10), 2'd2);
      adv();
      apply({PLAIN, 26'h1}, 2'd1);
      chk("R9 word short", idle(), 36'h0);
      adv();
      chk("R9 kept", ctx(), ectx(10, 10'b10));
      apply({PLAIN, 26'h1}, 2'd2);
      chk("R9 word ok", outs(), o32({PLAIN, 26'h1}));
      adv();
      apply(32'h1234_5678, 2'd0);
      chk("R9 half short", idle(), 36'h0);
      adv();
      chk("R9 kept2", ctx(), ectx(9, 10'b1));
      apply(32'h1234_5678, 2'd1);
      chk("R9 half ok", outs(), o16(16'h1234));
      adv();

      // R7 replacement while bits pending
      apply(swword(16'h0101, 10'b1100), 2'd2);
      adv();
      apply(swword(16'hCAFE, 10'h155), 2'd2);
      chk("R7 switch in word slot", outs(), osw(16'hCAFE));
      adv();
      chk("R7 replaced", ctx(), ectx(10, 10'h155));
      apply(32'hABCD_0000, 2'd2);
      chk("R7 new bit0", outs(), o16(16'hABCD));
      adv();

      // R8 redirect
      redirect = 1'b1;
      apply({PLAIN, 26'h7}, 2'd2);
      chk("R8 no issue", idle(), 36'h0);
      adv();
      redirect = 1'b0;
      chk("R8 cleared", ctx(), ectx(0, 10'h0));
      apply({PLAIN, 26'h7}, 2'd2);
      chk("R8 word after", outs(), o32({PLAIN, 26'h7}));
      adv();

      // R10 restore, and redirect priority
      restore_en = 1'b1; restore_bits = 10'b101; restore_cnt = 4'd3;
      apply({PLAIN, 26'h9}, 2'd2);
      chk("R10 no issue", idle(), 36'h0);
      adv();
      restore_en = 1'b0;
      chk("R10 loaded", ctx(), ectx(3, 10'b101));
      apply(32'h4444_5555, 2'd2);
      chk("R10 slot0", outs(), o16(16'h4444));
      adv();
      apply({PLAIN, 26'h2}, 2'd2);
      chk("R10 slot1", outs(), o32({PLAIN, 26'h2}));
      adv();
      apply(32'h6666_7777, 2'd2);
      chk("R10 slot2", outs(), o16(16'h6666));
      adv();
      chk("R10 empty", ctx(), ectx(0, 10'h0));
      restore_en = 1'b1; restore_bits = 10'h3FF; restore_cnt = 4'd15;
      apply(32'h0, 2'd0);
      adv();
      restore_en = 1'b0;
      chk("R10 clipped", ctx(), ectx(10, 10'h3FF));
      redirect = 1'b1; restore_en = 1'b1; restore_cnt = 4'd5;
      adv();
      redirect = 1'b0; restore_en = 1'b0;
      chk("R8 beats restore", ctx(), ectx(0, 10'h0));

      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule